// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines from peripherals and merges them with a register of requests raised by software. Each request is masked by an enable register. An enable bit is set through one register address and cleared through a different address. A route register sends each unmasked request either to the fast-interrupt line (`fiq_o`) or to the normal-interrupt line (`irq_o`).

A bank of prioritised vector slots binds chosen sources to handler addresses. A read of the vector-address register returns the handler of the most urgent bound request, or a default address when only unbound requests are waiting. That read also marks the slot as in service. The slot stays in service until software writes the vector-address register.

All registers sit on a plain synchronous register bus. There is no valid/ready handshake and no back-pressure: every access takes effect in the cycle its strobe is sampled. Read data is registered and appears one cycle after `bus_rd`. `bus_rdata` holds its value between reads. Software must not assert `bus_rd` and `bus_wr` in the same cycle.

Register word addresses:

| Address | Register |
|---|---|
| 0x00 | IRQ status |
| 0x01 | FIQ status |
| 0x02 | raw status |
| 0x03 | route |
| 0x04 | enable-set (reads back the enable mask) |
| 0x05 | enable-clear |
| 0x06 | software-set |
| 0x07 | software-clear |
| 0x0C | vector address |
| 0x0D | default address |
| 0x20+n | slot n handler address |
| 0x30+n | slot n control |

Top module: `vec_irq_ctrl`

## Requirements
- R1: The raw status register (0x02) reads as the bitwise OR of `irq_in` and the software request register.
- R2: A route bit of 1 sends its source to FIQ and a route bit of 0 sends it to IRQ. The FIQ status register (0x01) is raw AND enable AND route. The IRQ status register (0x00) is raw AND enable AND NOT route. `fiq_o` is high whenever FIQ status is non-zero.
- R3: Writing 0x04 sets the enable bits that are written as 1. Writing 0x05 clears the enable bits that are written as 1. Zero bits written to either address leave the enable mask unchanged.
- R4: Writing 0x06 sets the software request bits that are written as 1. Writing 0x07 clears the bits that are written as 1. For example, 0x5 cleared with 0x1 becomes 0x4.
- R5: In a slot control word, bit 5 enables the slot and bits 4:0 name the bound source. A slot with bit 5 clear binds nothing.
- R6: When several enabled slots have pending IRQ-routed sources, the slot with the lowest number wins.
- R7: A read of 0x0C returns the winning slot's handler address when that slot is eligible. Otherwise it returns the default address (0x0D).
- R8: A read of 0x0C with an eligible slot puts that slot in service. While any slot is in service, `irq_o` is raised only by a pending slot with a strictly lower number, and unbound requests are held off.
- R9: Any write to 0x0C releases the most recently serviced slot and restores the slot it had interrupted. A write with nothing in service has no effect.
- R10: Reads of the enable-clear register (0x05) and the software-clear register (0x07) return zero.
- R11: After reset, all registers are zero, nothing is in service, and `fiq_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Level request lines from peripherals |
| bus_addr | input | 6 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_rd` |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The embedded assertions check several rules on every cycle:
- the enable-clear and software-clear strobes leave the written bits at zero;
- the enable mask stays stable when no enable write occurs;
- a fully masked block raises nothing;
- the priority pick never skips a lower-numbered hit;
- a slot is pushed into service only when it outranks the current one;
- an acknowledge releases exactly one slot.

Only the bench's scenarios show the end-to-end behaviour: the handler address returned under nesting, the recovery of an interrupted slot after an acknowledge, the fall-back to the default address for unbound sources, and the interplay of route, software requests and slot bindings under random traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DW     = 32;
  localparam int BUS_AW = 6;
  localparam int SEL_W  = 4;

  localparam logic [BUS_AW-1:0] A_IRQ_STAT = 6'h00;
  localparam logic [BUS_AW-1:0] A_FIQ_STAT = 6'h01;
  localparam logic [BUS_AW-1:0] A_RAW      = 6'h02;
  localparam logic [BUS_AW-1:0] A_ROUTE    = 6'h03;
  localparam logic [BUS_AW-1:0] A_EN_SET   = 6'h04;
  localparam logic [BUS_AW-1:0] A_EN_CLR   = 6'h05;
  localparam logic [BUS_AW-1:0] A_SWI_SET  = 6'h06;
  localparam logic [BUS_AW-1:0] A_SWI_CLR  = 6'h07;
  localparam logic [BUS_AW-1:0] A_VEC      = 6'h0C;
  localparam logic [BUS_AW-1:0] A_DEF      = 6'h0D;

  localparam logic [1:0] BANK_ADDR = 2'b10;
  localparam logic [1:0] BANK_CTL  = 2'b11;

  typedef struct packed {
    logic       en;
    logic [4:0] src;
  } slot_ctl_t;
endpackage

// File: rtl/vic_src_gate.sv
module vic_src_gate #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic               route_we,
  input  logic               en_set_we,
  input  logic               en_clr_we,
  input  logic               swi_set_we,
  input  logic               swi_clr_we,
  output logic [NUM_SRC-1:0] raw,
  output logic [NUM_SRC-1:0] fiq_stat,
  output logic [NUM_SRC-1:0] irq_stat,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] route_q,
  output logic [NUM_SRC-1:0] swi_q,
  output logic               fiq_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      swi_q   <= '0;
    end else begin
      if (route_we) route_q <= wr_data;
      if (en_set_we)      en_q <= en_q | wr_data;
      else if (en_clr_we) en_q <= en_q & ~wr_data;
      if (swi_set_we)      swi_q <= swi_q | wr_data;
      else if (swi_clr_we) swi_q <= swi_q & ~wr_data;
    end
  end

  assign raw      = irq_in | swi_q;
  assign fiq_stat = raw & en_q & route_q;
  assign irq_stat = raw & en_q & ~route_q;
  assign fiq_req  = |fiq_stat;

  p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_we && !en_set_we) |=> ((en_q & $past(wr_data)) == '0));
  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_clr_we && !en_set_we) |=> $stable(en_q));
  p_swi_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_clr_we && !swi_set_we) |=> ((swi_q & $past(wr_data)) == '0));
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!fiq_req && irq_stat == '0));
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_stat,
  input  logic [DW-1:0]      wr_data,
  input  logic [SEL_W-1:0]   slot_sel,
  input  logic               addr_we,
  input  logic               ctl_we,
  output logic [DW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_ctl,
  output logic               hit,
  output logic [SLOT_W-1:0]  hit_idx,
  output logic [DW-1:0]      hit_addr,
  output logic [NUM_SRC-1:0] vect_mask
);
  slot_ctl_t         ctl_q  [NUM_SLOTS];
  logic [DW-1:0]     addr_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [31:0]       stat_pad;

  assign stat_pad = 32'(irq_stat);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rst_n) begin
        ctl_q[i]  <= '0;
        addr_q[i] <= '0;
      end else if (slot_sel == SEL_W'(i)) begin
        if (ctl_we)  ctl_q[i]  <= wr_data[5:0];
        if (addr_we) addr_q[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_hit[g] = ctl_q[g].en && stat_pad[ctl_q[g].src];
  end

  always_comb begin
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (ctl_q[i].en) m[ctl_q[i].src] = 1'b1;
    vect_mask = m[NUM_SRC-1:0];
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (slot_hit[i]) hit_idx = SLOT_W'(i);
  end
  assign hit      = |slot_hit;
  assign hit_addr = addr_q[hit_idx];

  always_comb begin
    rd_addr = '0;
    rd_ctl  = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slot_sel == SEL_W'(i)) begin
        rd_addr = addr_q[i];
        rd_ctl  = DW'(ctl_q[i]);
      end
  end

  p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (slot_hit[hit_idx] &&
             ((slot_hit & ((NUM_SLOTS'(1) << hit_idx) - NUM_SLOTS'(1))) == '0)));
  p_disabled_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[hit_idx].en) |-> !hit);
endmodule

// File: rtl/vic_svc_track.sv
module vic_svc_track #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_idx,
  input  logic              pop,
  output logic              busy,
  output logic [SLOT_W-1:0] top_idx
);
  logic [NUM_SLOTS-1:0] svc_q, svc_d;

  always_comb begin
    top_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (svc_q[i]) top_idx = SLOT_W'(i);
  end
  assign busy = |svc_q;

  always_comb begin
    svc_d = svc_q;
    if (pop && busy) svc_d[top_idx] = 1'b0;
    if (push)        svc_d[push_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  p_push_outranks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && busy) |-> (push_idx < top_idx));
  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && busy) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(svc_q));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_rd,
  output logic [DW-1:0]      bus_rdata,
  output logic               fiq_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] raw, fiq_stat, irq_stat, en_q, route_q, swi_q, vect_mask;
  logic               fiq_req;
  logic [DW-1:0]      def_q, slot_rd_addr, slot_rd_ctl, hit_addr, vec_value;
  logic               hit, busy, eligible, nonvec_pend, vec_rd, push, pop;
  logic [SLOT_W-1:0]  hit_idx, top_idx;

  function automatic logic wr_at(input logic [BUS_AW-1:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  vic_src_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk, .rst_n, .irq_in,
    .wr_data    (bus_wdata[NUM_SRC-1:0]),
    .route_we   (wr_at(A_ROUTE)),
    .en_set_we  (wr_at(A_EN_SET)),
    .en_clr_we  (wr_at(A_EN_CLR)),
    .swi_set_we (wr_at(A_SWI_SET)),
    .swi_clr_we (wr_at(A_SWI_CLR)),
    .raw, .fiq_stat, .irq_stat, .en_q, .route_q, .swi_q, .fiq_req
  );

  vic_slot_bank #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk, .rst_n, .irq_stat,
    .wr_data  (bus_wdata),
    .slot_sel (bus_addr[SEL_W-1:0]),
    .addr_we  (bus_wr && bus_addr[5:4] == BANK_ADDR),
    .ctl_we   (bus_wr && bus_addr[5:4] == BANK_CTL),
    .rd_addr  (slot_rd_addr),
    .rd_ctl   (slot_rd_ctl),
    .hit, .hit_idx, .hit_addr, .vect_mask
  );

  vic_svc_track #(.NUM_SLOTS(NUM_SLOTS)) u_svc (
    .clk, .rst_n,
    .push, .push_idx (hit_idx), .pop,
    .busy, .top_idx
  );

  assign eligible    = hit && (!busy || hit_idx < top_idx);
  assign nonvec_pend = |(irq_stat & ~vect_mask);
  assign vec_rd      = bus_rd && bus_addr == A_VEC;
  assign push        = vec_rd && eligible;
  assign pop         = wr_at(A_VEC);
  assign vec_value   = eligible ? hit_addr : def_q;

  assign irq_o = eligible || (!busy && nonvec_pend);
  assign fiq_o = fiq_req;

  always_ff @(posedge clk) begin
    if (!rst_n)           def_q <= '0;
    else if (wr_at(A_DEF)) def_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr[5:4])
        BANK_ADDR: bus_rdata <= slot_rd_addr;
        BANK_CTL:  bus_rdata <= slot_rd_ctl;
        default: begin
          case (bus_addr)
            A_IRQ_STAT: bus_rdata <= DW'(irq_stat);
            A_FIQ_STAT: bus_rdata <= DW'(fiq_stat);
            A_RAW:      bus_rdata <= DW'(raw);
            A_ROUTE:    bus_rdata <= DW'(route_q);
            A_EN_SET:   bus_rdata <= DW'(en_q);
            A_SWI_SET:  bus_rdata <= DW'(swi_q);
            A_VEC:      bus_rdata <= vec_value;
            A_DEF:      bus_rdata <= def_q;
            default:    bus_rdata <= '0;
          endcase
        end
      endcase
    end
  end

  p_clr_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_EN_CLR || bus_addr == A_SWI_CLR)) |=> (bus_rdata == '0));
  p_vec_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !hit) |=> (bus_rdata == $past(def_q)));
  p_nested_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit) |-> !irq_o);
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  import vic_pkg::*;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic        fiq_o, irq_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_en = '0, m_sel = '0, m_soft = '0, m_def = '0;
  logic [31:0] m_addr [16];
  logic [5:0]  m_ctl  [16];
  logic [15:0] m_svc = '0;

  always #4 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk, .rst_n, .irq_in, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
    .bus_rdata, .fiq_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_raw();
    return irq_in | m_soft;
  endfunction
  function automatic logic [31:0] f_irqst();
    return f_raw() & m_en & ~m_sel;
  endfunction
  function automatic int f_hit();
    logic [31:0] s = f_irqst();
    for (int i = 0; i < 16; i++)
      if (m_ctl[i][5] && s[m_ctl[i][4:0]]) return i;
    return -1;
  endfunction
  function automatic int f_top();
    for (int i = 0; i < 16; i++) if (m_svc[i]) return i;
    return 16;
  endfunction
  function automatic logic f_elig();
    int h = f_hit();
    return h >= 0 && h < f_top();
  endfunction
  function automatic logic f_irq_o();
    logic [31:0] vm = '0;
    for (int i = 0; i < 16; i++) if (m_ctl[i][5]) vm[m_ctl[i][4:0]] = 1'b1;
    return f_elig() || (m_svc == '0 && |(f_irqst() & ~vm));
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    case (a)
      A_EN_SET:  m_en   = m_en | d;
      A_EN_CLR:  m_en   = m_en & ~d;
      A_ROUTE:   m_sel  = d;
      A_SWI_SET: m_soft = m_soft | d;
      A_SWI_CLR: m_soft = m_soft & ~d;
      A_DEF:     m_def  = d;
      A_VEC:     if (m_svc != '0) m_svc[f_top()] = 1'b0;
      default: begin
        if (a[5:4] == BANK_ADDR) m_addr[a[3:0]] = d;
        if (a[5:4] == BANK_CTL)  m_ctl[a[3:0]]  = d[5:0];
      end
    endcase
    @(negedge clk);
    bus_wr = 0;
    #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic vec_chk(input string req);
    logic [31:0] exp, d;
    int h = f_hit();
    if (f_elig()) begin
      exp = m_addr[h];
      m_svc[h] = 1'b1;
    end else exp = m_def;
    rd(A_VEC, d);
    check(req, d, exp);
  endtask

  task automatic outs_chk(input string req);
    check({req, " irq_o"}, 32'(irq_o), 32'(f_irq_o()));
    check({req, " fiq_o"}, 32'(fiq_o), 32'(|(f_raw() & m_en & m_sel)));
  endtask

  task automatic drive_in(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < 16; i++) begin m_addr[i] = '0; m_ctl[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    check("R11 irq_o", 32'(irq_o), 0);
    check("R11 fiq_o", 32'(fiq_o), 0);
    rd_chk("R11 enable", A_EN_SET, 0);
    rd_chk("R11 route", A_ROUTE, 0);
    rd_chk("R11 vector", A_VEC, 0);

    // R3: set / clear with ones only
    wr(A_EN_SET, 32'hF0);   rd_chk("R3 set", A_EN_SET, 32'hF0);
    wr(A_EN_SET, 32'h0);    rd_chk("R3 zero set", A_EN_SET, 32'hF0);
    wr(A_EN_CLR, 32'h30);   rd_chk("R3 clear", A_EN_SET, 32'hC0);
    wr(A_EN_CLR, 32'h0);    rd_chk("R3 zero clear", A_EN_SET, 32'hC0);

    // R4 and R10: software requests
    wr(A_SWI_SET, 32'h5);   rd_chk("R4 set", A_SWI_SET, 32'h5);
    wr(A_SWI_CLR, 32'h1);   rd_chk("R4 clear", A_SWI_SET, 32'h4);
    rd_chk("R10 swi clear reads zero", A_SWI_CLR, 0);
    rd_chk("R10 en clear reads zero", A_EN_CLR, 0);
    wr(A_SWI_CLR, 32'h4);

    // R1: raw status merges lines and software
    drive_in(32'h100);
    wr(A_SWI_SET, 32'h1);
    rd_chk("R1 raw", A_RAW, 32'h101);
    wr(A_SWI_CLR, 32'h1);

    // R2: routing
    wr(A_EN_SET, 32'h6C0);
    drive_in(32'h40);
    outs_chk("R2 to irq");
    wr(A_ROUTE, 32'h40);
    outs_chk("R2 to fiq");
    rd_chk("R2 fiq status", A_FIQ_STAT, 32'h40);
    rd_chk("R2 irq status", A_IRQ_STAT, 32'h0);
    wr(A_ROUTE, 32'h0);

    // R5 R6 R7 R8 R9: slots and nesting
    wr(A_DEF, 32'hDEF0);
    wr(6'h20, 32'h1000); wr(6'h30, 32'h26);
    wr(6'h21, 32'h2000); wr(6'h31, 32'h2A);
    wr(6'h32, 32'h07);
    rd_chk("R5 ctl readback", 6'h30, 32'h26);
    drive_in(32'h400);
    vec_chk("R5 slot1 handler");
    drive_in(32'h440);
    outs_chk("R8 higher preempts");
    vec_chk("R6 slot0 handler");
    outs_chk("R8 nothing higher");
    wr(A_VEC, 0);
    outs_chk("R9 restored slot1");
    vec_chk("R9 slot0 again");
    wr(A_VEC, 0); wr(A_VEC, 0);
    wr(A_VEC, 0);
    outs_chk("R9 empty ack");
    vec_chk("R6 both pending picks slot0");
    wr(A_VEC, 0);
    drive_in(32'h80);
    outs_chk("R7 unbound pending");
    vec_chk("R7 default address");
    drive_in(32'h480);
    vec_chk("R8 slot1 over unbound");
    drive_in(32'h80);
    outs_chk("R8 unbound blocked");
    wr(A_VEC, 0);
    outs_chk("R9 unbound released");

    // random phase
    seed = $urandom(32'h5EED_1234);
    for (int i = 2; i < 16; i++) begin
      wr(6'(6'h20 + i), $urandom);
      wr(6'(6'h30 + i), {26'b0, 1'($urandom_range(0, 1)), 5'($urandom)});
    end
    for (int it = 0; it < 600; it++) begin
      logic [31:0] r = $urandom & $urandom & $urandom;
      case ($urandom_range(0, 8))
        0: drive_in(r);
        1: wr(A_EN_SET, r);
        2: wr(A_EN_CLR, r);
        3: wr(A_ROUTE, r & $urandom);
        4: wr(A_SWI_SET, r & $urandom);
        5: wr(A_SWI_CLR, $urandom);
        6: vec_chk("R7 random vector");
        7: wr(A_VEC, 0);
        default: rd_chk("R1 random raw", A_RAW, f_raw());
      endcase
      outs_chk("R8 random outputs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule